// File: doc/BRIEF.md
# Debug Breakpoint and Watchpoint Unit

This unit sits next to a CPU core. It raises debug breaks from four programmable address comparators and from the software-breakpoint instruction. Each comparator watches either the instruction fetch address or the data-access address. It can match a single address, or an aligned range when it is told to ignore a number of low address bits. When an enabled comparator matches, the unit takes one of two actions, chosen by a control bit. It either asserts a halt request that stops the core for the debugger, or it asserts a loop-hold request that keeps the core re-running the current instruction. The unit never drives any interrupt or DMA mask, so interrupt and DMA requests are still serviced while the core loops.

The unit also decides what the software-breakpoint instruction does. While breakpoints are globally enabled, that instruction raises a break like a comparator hit. While they are disabled, it becomes a one-cycle illegal-instruction trap, and a sticky status bit records the trap. Software polls a status register through a simple register port to learn which comparators fired. It releases a break by writing 1 to the break flag.

Top module: `dbg_brk_unit`

## Requirements
- R1: A synchronous active-high reset clears halt_o, loop_hold_o, illegal_trap_o and every status bit, so the status register (address 1) reads 0.
- R2: A comparator of type execute (cfg bits [1:0] = 00) hits only in a cycle with insn_valid_i high and pc_i equal to its address under the mask. A stalled PC (insn_valid_i low) and data accesses do not trigger it.
- R3: A comparator compares daddr_i when its type is read (01, needs drd_i), write (10, needs dwr_i) or read-or-write (11, needs either strobe).
- R4: The ignore count (cfg bits [8:4]) masks that many low address bits in the compare. A count above 23 acts as 23.
- R5: A comparator hits only when its own enable (cfg bit 2) and the global enable (control register address 0, bit 0) are both 1.
- R6: Status bits [3:0] are sticky and record every comparator that hit in the same cycle. Status bits [9:8] hold the lowest index among the latest hits.
- R7: The action bit (control bit 1) selects the break action. With 0 a break asserts halt_o. With 1 it asserts loop_hold_o. The chosen output and the break flag (status bit 6) appear one clock after the hit. The output stays high until the break flag is cleared, and halt_o and loop_hold_o are never high together.
- R8: With global enable 1, a brk_decode_i pulse raises a break. It sets status bit 4 and the break flag and does not trap.
- R9: With global enable 0, a brk_decode_i pulse gives a one-cycle illegal_trap_o pulse and sets status bit 5. It raises no halt or loop-hold and does not set the break flag.
- R10: Writing 1 to a status bit clears it. A hit in the same cycle as the clear wins, and the bit stays set.
- R11: Register map: 0 control, 1 status, 2+2i comparator i address [23:0], 3+2i comparator i configuration. Reads return data one clock after reg_rd_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_i | input | 24 | Fetch/execute address |
| insn_valid_i | input | 1 | An instruction at pc_i executes this cycle |
| brk_decode_i | input | 1 | Software-breakpoint instruction decoded |
| daddr_i | input | 24 | Data access address |
| drd_i | input | 1 | Data read strobe |
| dwr_i | input | 1 | Data write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 24 | Register write data |
| reg_rd_i | input | 1 | Register read strobe |
| reg_rdata_o | output | 24 | Registered read data |
| halt_o | output | 1 | Debug halt request |
| loop_hold_o | output | 1 | Loop-on-current-instruction request |
| illegal_trap_o | output | 1 | One-cycle illegal-instruction trap |

## Verification
The case hardest to reach is a status clear that lands in the same clock as a fresh comparator hit. It is only visible if the register write and the data strobe reach the ports in exactly the same cycle. The bench drives both at one falling edge and then reads the status back to confirm that the hit survived. The clamp of an oversized ignore count is also easy to miss. One comparator is set to count 31 and probed with one address inside the 23-bit range and one outside it. An unclamped mask would accept both.

// File: rtl/dbg_brk_pkg.sv
package dbg_brk_pkg;
  typedef enum logic [1:0] {
    BT_EXEC  = 2'b00,
    BT_READ  = 2'b01,
    BT_WRITE = 2'b10,
    BT_RW    = 2'b11
  } brk_type_e;

  localparam int REG_CTRL     = 0;
  localparam int REG_STAT     = 1;
  localparam int REG_CMP_BASE = 2;
  localparam int ST_SRC_LSB   = 8;
endpackage

// File: rtl/dbg_brk_cmp.sv
module dbg_brk_cmp #(
  parameter int AW = 24,
  parameter int CW = 5
) (
  input  logic          en_i,
  input  logic [1:0]    type_i,
  input  logic [AW-1:0] base_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [AW-1:0] pc_i,
  input  logic          insn_valid_i,
  input  logic [AW-1:0] daddr_i,
  input  logic          drd_i,
  input  logic          dwr_i,
  output logic          hit_o
);
  import dbg_brk_pkg::*;

  localparam logic [CW-1:0] CNT_MAX = CW'(AW - 1);

  logic [CW-1:0] eff_cnt;
  logic [AW-1:0] mask;
  logic          pc_eq, da_eq;

  always_comb begin
    eff_cnt = (cnt_i > CNT_MAX) ? CNT_MAX : cnt_i;
    mask    = {AW{1'b1}} << eff_cnt;
    pc_eq   = ((pc_i ^ base_i) & mask) == '0;
    da_eq   = ((daddr_i ^ base_i) & mask) == '0;
    unique case (brk_type_e'(type_i))
      BT_EXEC:  hit_o = en_i & insn_valid_i & pc_eq;
      BT_READ:  hit_o = en_i & drd_i & da_eq;
      BT_WRITE: hit_o = en_i & dwr_i & da_eq;
      default:  hit_o = en_i & (drd_i | dwr_i) & da_eq;
    endcase
  end
endmodule

// File: rtl/dbg_brk_prio.sv
module dbg_brk_prio #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req_i,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/dbg_brk_unit.sv
module dbg_brk_unit #(
  parameter int NUM_CMP = 4,
  parameter int AW      = 24,
  parameter int RAW     = 4,
  parameter int CW      = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [AW-1:0]  pc_i,
  input  logic           insn_valid_i,
  input  logic           brk_decode_i,
  input  logic [AW-1:0]  daddr_i,
  input  logic           drd_i,
  input  logic           dwr_i,
  input  logic [RAW-1:0] reg_addr_i,
  input  logic           reg_we_i,
  input  logic [AW-1:0]  reg_wdata_i,
  input  logic           reg_rd_i,
  output logic [AW-1:0]  reg_rdata_o,
  output logic           halt_o,
  output logic           loop_hold_o,
  output logic           illegal_trap_o
);
  import dbg_brk_pkg::*;

  localparam int DW      = AW;
  localparam int SRCW    = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1;
  localparam int ST_SW   = NUM_CMP;
  localparam int ST_ILL  = NUM_CMP + 1;
  localparam int ST_FLAG = NUM_CMP + 2;

  // configuration state
  logic                ctrl_en_q, ctrl_loop_q;
  logic [AW-1:0]       cmp_addr_q [NUM_CMP];
  logic [1:0]          cmp_type_q [NUM_CMP];
  logic [NUM_CMP-1:0]  cmp_en_q;
  logic [CW-1:0]       cmp_cnt_q  [NUM_CMP];

  // status state
  logic [NUM_CMP-1:0]  hit_q;
  logic                sw_q, ill_q, flag_q;
  logic [SRCW-1:0]     src_q;

  logic [NUM_CMP-1:0]  hit_vec;
  logic [SRCW-1:0]     prio_idx;
  logic                stat_we, brk_evt, sw_evt, ill_evt;
  logic [DW-1:0]       rd_mux;

  assign stat_we = reg_we_i && (reg_addr_i == RAW'(REG_STAT));
  assign sw_evt  = brk_decode_i & ctrl_en_q;
  assign ill_evt = brk_decode_i & ~ctrl_en_q;
  assign brk_evt = (|hit_vec) | sw_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en_q   <= 1'b0;
      ctrl_loop_q <= 1'b0;
    end else if (reg_we_i && reg_addr_i == RAW'(REG_CTRL)) begin
      ctrl_en_q   <= reg_wdata_i[0];
      ctrl_loop_q <= reg_wdata_i[1];
    end
  end

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    localparam logic [RAW-1:0] A_ADDR = RAW'(REG_CMP_BASE + 2 * g);
    localparam logic [RAW-1:0] A_CFG  = RAW'(REG_CMP_BASE + 2 * g + 1);

    always_ff @(posedge clk) begin
      if (rst) begin
        cmp_addr_q[g] <= '0;
        cmp_type_q[g] <= '0;
        cmp_en_q[g]   <= 1'b0;
        cmp_cnt_q[g]  <= '0;
      end else if (reg_we_i) begin
        if (reg_addr_i == A_ADDR) cmp_addr_q[g] <= reg_wdata_i;
        if (reg_addr_i == A_CFG) begin
          cmp_type_q[g] <= reg_wdata_i[1:0];
          cmp_en_q[g]   <= reg_wdata_i[2];
          cmp_cnt_q[g]  <= reg_wdata_i[4 +: CW];
        end
      end
    end

    dbg_brk_cmp #(.AW(AW), .CW(CW)) u_cmp (
      .en_i         (cmp_en_q[g] & ctrl_en_q),
      .type_i       (cmp_type_q[g]),
      .base_i       (cmp_addr_q[g]),
      .cnt_i        (cmp_cnt_q[g]),
      .pc_i         (pc_i),
      .insn_valid_i (insn_valid_i),
      .daddr_i      (daddr_i),
      .drd_i        (drd_i),
      .dwr_i        (dwr_i),
      .hit_o        (hit_vec[g])
    );
  end

  dbg_brk_prio #(.N(NUM_CMP), .IW(SRCW)) u_prio (
    .req_i (hit_vec),
    .idx_o (prio_idx)
  );

  // status: write-one-to-clear, new events win over the clear
  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q          <= '0;
      sw_q           <= 1'b0;
      ill_q          <= 1'b0;
      flag_q         <= 1'b0;
      src_q          <= '0;
      illegal_trap_o <= 1'b0;
      halt_o         <= 1'b0;
      loop_hold_o    <= 1'b0;
    end else begin
      hit_q  <= (hit_q  & ~(stat_we ? reg_wdata_i[NUM_CMP-1:0] : '0)) | hit_vec;
      sw_q   <= (sw_q   & ~(stat_we & reg_wdata_i[ST_SW]))   | sw_evt;
      ill_q  <= (ill_q  & ~(stat_we & reg_wdata_i[ST_ILL]))  | ill_evt;
      flag_q <= (flag_q & ~(stat_we & reg_wdata_i[ST_FLAG])) | brk_evt;
      if (|hit_vec) src_q <= prio_idx;
      illegal_trap_o <= ill_evt;
      if (brk_evt) begin
        halt_o      <= ~ctrl_loop_q;
        loop_hold_o <= ctrl_loop_q;
      end else if (stat_we && reg_wdata_i[ST_FLAG]) begin
        halt_o      <= 1'b0;
        loop_hold_o <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (reg_addr_i == RAW'(REG_CTRL)) begin
      rd_mux[1:0] = {ctrl_loop_q, ctrl_en_q};
    end else if (reg_addr_i == RAW'(REG_STAT)) begin
      rd_mux[NUM_CMP-1:0]         = hit_q;
      rd_mux[ST_SW]               = sw_q;
      rd_mux[ST_ILL]              = ill_q;
      rd_mux[ST_FLAG]             = flag_q;
      rd_mux[ST_SRC_LSB +: SRCW]  = src_q;
    end
    for (int g = 0; g < NUM_CMP; g++) begin
      if (reg_addr_i == RAW'(REG_CMP_BASE + 2 * g))
        rd_mux = cmp_addr_q[g];
      if (reg_addr_i == RAW'(REG_CMP_BASE + 2 * g + 1))
        rd_mux = DW'({cmp_cnt_q[g], 1'b0, cmp_en_q[g], cmp_type_q[g]});
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata_o <= '0;
    else if (reg_rd_i) reg_rdata_o <= rd_mux;
  end
endmodule

// File: rtl/dbg_brk_chk.sv
module dbg_brk_chk #(
  parameter int NUM_CMP = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               brk_decode_i,
  input logic               en_q,
  input logic [NUM_CMP-1:0] hit_vec,
  input logic [NUM_CMP-1:0] hit_q,
  input logic               halt_o,
  input logic               loop_hold_o,
  input logic               illegal_trap_o
);
  // R7: the two break actions are mutually exclusive
  assert_one_action_R7: assert property (@(posedge clk) disable iff (rst)
    !(halt_o && loop_hold_o));

  // R7/R8: a break output only starts after a comparator hit or an enabled BRK
  assert_break_cause_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(halt_o || loop_hold_o) |-> $past((|hit_vec) || (brk_decode_i && en_q)));

  // R9: a disabled BRK traps in the next cycle
  assert_brk_trap_R9: assert property (@(posedge clk) disable iff (rst)
    (brk_decode_i && !en_q) |=> illegal_trap_o);

  // R9: the trap only follows a disabled BRK
  assert_trap_cause_R9: assert property (@(posedge clk) disable iff (rst)
    illegal_trap_o |-> $past(brk_decode_i && !en_q));

  // R8: an enabled BRK never traps
  assert_brk_no_trap_R8: assert property (@(posedge clk) disable iff (rst)
    (brk_decode_i && en_q) |=> !illegal_trap_o);

  // R6/R10: every hit is recorded, even against a simultaneous clear
  assert_hit_recorded_R10: assert property (@(posedge clk) disable iff (rst)
    (|hit_vec) |=> ((hit_q & $past(hit_vec)) == $past(hit_vec)));
endmodule

bind dbg_brk_unit dbg_brk_chk #(.NUM_CMP(NUM_CMP)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .brk_decode_i   (brk_decode_i),
  .en_q           (ctrl_en_q),
  .hit_vec        (hit_vec),
  .hit_q          (hit_q),
  .halt_o         (halt_o),
  .loop_hold_o    (loop_hold_o),
  .illegal_trap_o (illegal_trap_o)
);

// File: tb/dbg_brk_unit_tb.sv
module dbg_brk_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] pc = '0, daddr = '0, wdata = '0;
  logic        ivalid = 0, brk = 0, drd = 0, dwr = 0, we = 0, rd = 0;
  logic [3:0]  addr = '0;
  logic [23:0] rdata;
  logic        halt, loop_h, trap;
  int          n_tests = 0, n_fail = 0;
  logic        done = 0;
  logic [23:0] v;

  always #4 clk = ~clk;

  dbg_brk_unit u_dut (
    .clk(clk), .rst(rst), .pc_i(pc), .insn_valid_i(ivalid), .brk_decode_i(brk),
    .daddr_i(daddr), .drd_i(drd), .dwr_i(dwr), .reg_addr_i(addr), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rd_i(rd), .reg_rdata_o(rdata), .halt_o(halt),
    .loop_hold_o(loop_h), .illegal_trap_o(trap)
  );

  typedef struct packed {
    logic        iv;
    logic [23:0] pc;
    logic        rd;
    logic        wr;
    logic [23:0] da;
    logic [3:0]  hits;
    logic [1:0]  src;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 24'h001000, 1'b0, 1'b0, 24'h000000, 4'b0001, 2'd0},
    '{1'b0, 24'h001000, 1'b0, 1'b0, 24'h000000, 4'b0000, 2'd0},
    '{1'b1, 24'h001001, 1'b0, 1'b0, 24'h000000, 4'b0000, 2'd0},
    '{1'b0, 24'h000000, 1'b1, 1'b0, 24'h00200F, 4'b0010, 2'd1},
    '{1'b0, 24'h000000, 1'b1, 1'b0, 24'h002010, 4'b0000, 2'd0},
    '{1'b0, 24'h000000, 1'b0, 1'b1, 24'h00200F, 4'b0000, 2'd0},
    '{1'b0, 24'h000000, 1'b0, 1'b1, 24'h0030FF, 4'b0100, 2'd2},
    '{1'b0, 24'h000000, 1'b1, 1'b0, 24'h0030FF, 4'b0000, 2'd0},
    '{1'b0, 24'h000000, 1'b1, 1'b0, 24'h900000, 4'b1000, 2'd3},
    '{1'b0, 24'h000000, 1'b0, 1'b1, 24'hFFFFFF, 4'b1000, 2'd3},
    '{1'b0, 24'h000000, 1'b1, 1'b0, 24'h100000, 4'b0000, 2'd0},
    '{1'b0, 24'h000000, 1'b1, 1'b0, 24'h001000, 4'b0000, 2'd0},
    '{1'b1, 24'h900000, 1'b0, 1'b0, 24'h000000, 4'b0000, 2'd0},
    '{1'b1, 24'h001000, 1'b1, 1'b0, 24'h002000, 4'b0011, 2'd0},
    '{1'b0, 24'h000000, 1'b0, 1'b1, 24'h003100, 4'b0000, 2'd0},
    '{1'b1, 24'h001000, 1'b0, 1'b1, 24'h900000, 4'b1001, 2'd0}
  };

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [23:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [23:0] d);
    @(negedge clk); rd = 1; addr = a;
    @(negedge clk); rd = 0; d = rdata;
  endtask

  task automatic pulse(input logic i_v, input logic [23:0] p, input logic r,
                       input logic w, input logic [23:0] da, input logic b);
    @(negedge clk); ivalid = i_v; pc = p; drd = r; dwr = w; daddr = da; brk = b;
    @(negedge clk); ivalid = 0; drd = 0; dwr = 0; brk = 0;
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 halt", {23'd0, halt}, 24'd0);
    chk("R1 loop", {23'd0, loop_h}, 24'd0);
    chk("R1 trap", {23'd0, trap}, 24'd0);
    rd_reg(4'd1, v);
    chk("R1 status", v, 24'd0);

    // configure: cfg = type | en<<2 | count<<4
    wr_reg(4'd2, 24'h001000); wr_reg(4'd3, 24'h004);
    wr_reg(4'd4, 24'h002000); wr_reg(4'd5, 24'h045);
    wr_reg(4'd6, 24'h003000); wr_reg(4'd7, 24'h086);
    wr_reg(4'd8, 24'h804000); wr_reg(4'd9, 24'h1F7);
    wr_reg(4'd0, 24'h000001);

    // R11 register readback
    rd_reg(4'd8, v); chk("R11 cmp3 address", v, 24'h804000);
    rd_reg(4'd9, v); chk("R11 cmp3 config", v, 24'h0001F7);
    rd_reg(4'd0, v); chk("R11 control", v, 24'h000001);

    // R2 R3 R4 R6 R7 vector walk
    for (int i = 0; i < NV; i++) begin
      pulse(VEC[i].iv, VEC[i].pc, VEC[i].rd, VEC[i].wr, VEC[i].da, 1'b0);
      chk($sformatf("R7 halt vec%0d", i), {23'd0, halt}, {23'd0, VEC[i].hits != 0});
      rd_reg(4'd1, v);
      chk($sformatf("R2 R3 R4 hits vec%0d", i), {20'd0, v[3:0]}, {20'd0, VEC[i].hits});
      if (VEC[i].hits != 0) begin
        chk($sformatf("R6 source vec%0d", i), {22'd0, v[9:8]}, {22'd0, VEC[i].src});
        chk($sformatf("R7 flag vec%0d", i), {23'd0, v[6]}, 24'd1);
      end
      wr_reg(4'd1, 24'h00007F);
      chk($sformatf("R7 release vec%0d", i), {23'd0, halt}, 24'd0);
    end

    // R5 per-comparator enable
    wr_reg(4'd3, 24'h000);
    pulse(1'b1, 24'h001000, 1'b0, 1'b0, 24'h0, 1'b0);
    rd_reg(4'd1, v);
    chk("R5 comparator disabled", v[6:0], 7'd0);
    wr_reg(4'd3, 24'h004);

    // R5 global enable off, R9 BRK traps
    wr_reg(4'd0, 24'h000000);
    pulse(1'b0, 24'h0, 1'b1, 1'b0, 24'h002000, 1'b0);
    rd_reg(4'd1, v);
    chk("R5 global disabled", v[6:0], 7'd0);
    pulse(1'b0, 24'h0, 1'b0, 1'b0, 24'h0, 1'b1);
    chk("R9 trap pulse", {23'd0, trap}, 24'd1);
    chk("R9 no halt", {23'd0, halt}, 24'd0);
    @(negedge clk);
    chk("R9 trap one cycle", {23'd0, trap}, 24'd0);
    rd_reg(4'd1, v);
    chk("R9 status", v[6:0], 7'h20);
    wr_reg(4'd1, 24'h00007F);

    // R8 BRK with breakpoints enabled
    wr_reg(4'd0, 24'h000001);
    pulse(1'b0, 24'h0, 1'b0, 1'b0, 24'h0, 1'b1);
    chk("R8 halt", {23'd0, halt}, 24'd1);
    chk("R8 no trap", {23'd0, trap}, 24'd0);
    rd_reg(4'd1, v);
    chk("R8 status", v[6:0], 7'h50);
    wr_reg(4'd1, 24'h00007F);
    chk("R8 released", {23'd0, halt}, 24'd0);

    // R7 loop action, held until flag cleared
    wr_reg(4'd0, 24'h000003);
    pulse(1'b0, 24'h0, 1'b1, 1'b0, 24'h002005, 1'b0);
    chk("R7 loop set", {23'd0, loop_h}, 24'd1);
    chk("R7 no halt in loop mode", {23'd0, halt}, 24'd0);
    repeat (4) @(negedge clk);
    chk("R7 loop held", {23'd0, loop_h}, 24'd1);
    wr_reg(4'd1, 24'h000040);
    chk("R7 loop released", {23'd0, loop_h}, 24'd0);

    // R10 clear alone, then clear colliding with a new hit
    wr_reg(4'd1, 24'h00007F);
    rd_reg(4'd1, v);
    chk("R10 cleared", v[6:0], 7'd0);
    pulse(1'b0, 24'h0, 1'b1, 1'b0, 24'h002000, 1'b0);
    @(negedge clk); we = 1; addr = 4'd1; wdata = 24'h000002; drd = 1; daddr = 24'h002000;
    @(negedge clk); we = 0; drd = 0;
    rd_reg(4'd1, v);
    chk("R10 set wins over clear", {23'd0, v[1]}, 24'd1);

    summary();
  end
endmodule